// File: doc/BRIEF.md
# Banked Data Memory with Pointer Access

This block is the data store of a small 8-bit processor core. One 9-bit space holds the special function registers and the general purpose RAM. The space is split into four banks of 128 bytes. An access gives a 7-bit offset. For a direct access, two bank bits in the status register complete the address. Offset 0x00 is a virtual location: an access there is sent instead to the byte that the 8-bit pointer register names, and a separate status bit chooses the upper or lower half of the space.

The status register and the pointer register are held inside the block. Both are always visible on output ports. The ALU can overwrite the zero, digit-carry and carry bits in any cycle. The timer, the program counter low byte, the port and the other bank-0 control registers live outside the block. For those locations the block raises a strobe together with the effective address, and it samples the external read data. Reads are synchronous: the data appears one cycle after the request and holds until the next read.

Top module: `banked_dmem`

## Requirements
- R1: After reset, the status output is 0x18 (bits 4 and 3 set, all others clear), the pointer output is 0x00 and the read data is 0x00.
- R2: A direct access at a nonzero offset uses the effective address {status[6:5], offset}. Read data for a request in cycle N is on rd_data after the clock edge that ends cycle N.
- R3: An access at offset 0x00 uses the effective address {status[7], pointer[7:0]}.
- R4: An access at offset 0x00 whose resolved effective address again has offset 0 (pointer 0x00 or 0x80) reads 0x00. A write to it changes no register, no RAM byte and raises no external strobe.
- R5: Offset 0x03 is the status register and offset 0x04 is the pointer register in every bank, for both direct and pointer accesses. A pointer write loads all 8 bits.
- R6: A status write loads bits 7:5 and 2:0 from the write data. Bits 4 and 3 keep their value, which is 1.
- R7: When flag_we is high, status bits 2:0 take flag_in ({zero, digit carry, carry}) at the clock edge. This overrides a status write in the same cycle, and the flag update alone changes no other bit.
- R8: Offset 0x02 in any bank is external at address 0x002. In bank 0, offset 0x01 and offsets 0x05 to 0x1F are external at their effective address. For these, ext_rd/ext_wr follow rd_en/wr_en in the same cycle, ext_addr carries the address, and a read returns the value of ext_rd_data sampled in the request cycle.
- R9: In banks 1 to 3, offsets 0x01 and 0x05 to 0x1F are RAM. Offsets 0x20 to 0x7F are RAM in every bank.
- R10: A read and a write to the same location in one cycle return the old value. rd_data holds its value in cycles without rd_en.
- R11: Each access reaches at most one target: RAM, status, pointer or the external side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Offset within the bank; 0x00 selects pointer access |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the request |
| flag_we | input | 1 | ALU flag update enable |
| flag_in | input | 3 | New {zero, digit carry, carry} |
| status | output | 8 | Status register contents |
| pointer | output | 8 | Pointer register contents |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 9 | External effective address |
| ext_rd_data | input | 8 | External read data, valid in the request cycle |

## Verification
The assertions take ext_rd_data to be stable and valid in the cycle in which ext_rd is high, and they take the control inputs to be known once reset has been released. The bench drives ext_rd_data combinationally from ext_addr, so the first condition always holds, and it drives every input to a defined value at each falling edge. The random stimulus puts extra weight on offsets 0x00, 0x02, 0x03 and 0x04 and sets the pointer to arbitrary values. Pointer accesses therefore regularly land on the status register, the pointer itself, external locations and the null location. Read data from RAM bytes that have not yet been written is not compared.

// File: rtl/banked_dmem_pkg.sv
package banked_dmem_pkg;
  localparam int DW       = 8;
  localparam int OFS_W    = 7;
  localparam int BANK_W   = 2;
  localparam int EA_W     = BANK_W + OFS_W;
  localparam int RAM_BASE = 32;

  localparam logic [OFS_W-1:0] OFS_PTRDATA = 7'h00;
  localparam logic [OFS_W-1:0] OFS_TIMER   = 7'h01;
  localparam logic [OFS_W-1:0] OFS_PCLOW   = 7'h02;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 7'h03;
  localparam logic [OFS_W-1:0] OFS_POINTER = 7'h04;
  localparam logic [OFS_W-1:0] OFS_PORT    = 7'h05;

  typedef enum logic [2:0] {
    RG_NULL = 3'd0,
    RG_RAM  = 3'd1,
    RG_STAT = 3'd2,
    RG_PTR  = 3'd3,
    RG_EXT  = 3'd4
  } dmem_rgn_e;
endpackage

// File: rtl/banked_dmem_decode.sv
module banked_dmem_decode
  import banked_dmem_pkg::*;
#(
  parameter int P_OFS_W    = OFS_W,
  parameter int P_BANK_W   = BANK_W,
  parameter int P_DW       = DW,
  parameter int P_RAM_BASE = RAM_BASE,
  localparam int LEA_W     = P_OFS_W + P_BANK_W
) (
  input  logic [P_OFS_W-1:0]  addr,
  input  logic [P_BANK_W-1:0] bank_dir,
  input  logic                bank_ind,
  input  logic [P_DW-1:0]     ptr,
  output logic [LEA_W-1:0]    ea,
  output dmem_rgn_e           rgn,
  output logic [LEA_W-1:0]    ext_ea
);
  logic               use_ptr;
  logic [P_OFS_W-1:0] ofs;
  logic               bank0;
  logic               bank0_ext;

  assign use_ptr = (addr == OFS_PTRDATA);
  assign ea      = use_ptr ? LEA_W'({bank_ind, ptr}) : {bank_dir, addr};
  assign ofs     = ea[P_OFS_W-1:0];
  assign bank0   = (ea[LEA_W-1:P_OFS_W] == '0);

  // bank-0 only control window outside the mirrored registers
  assign bank0_ext = bank0 && ((ofs == OFS_TIMER) ||
                     ((ofs >= OFS_PORT) && (ofs < P_OFS_W'(P_RAM_BASE))));

  always_comb begin
    ext_ea = ea;
    if (ofs == OFS_PTRDATA)      rgn = RG_NULL;
    else if (ofs == OFS_STATUS)  rgn = RG_STAT;
    else if (ofs == OFS_POINTER) rgn = RG_PTR;
    else if (ofs == OFS_PCLOW) begin
      rgn    = RG_EXT;
      ext_ea = LEA_W'(OFS_PCLOW);
    end
    else if (bank0_ext)          rgn = RG_EXT;
    else                         rgn = RG_RAM;
  end
endmodule

// File: rtl/banked_dmem_status.sv
module banked_dmem_status
  import banked_dmem_pkg::*;
#(
  parameter int P_DW = DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [P_DW-1:0] wdata,
  input  logic            flag_we,
  input  logic [2:0]      flag_in,
  output logic [P_DW-1:0] status_q
);
  localparam logic [P_DW-1:0] RESET_VAL = P_DW'(8'h18);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= RESET_VAL;
    end else begin
      if (we) begin
        status_q[P_DW-1:5] <= wdata[P_DW-1:5];
        status_q[2:0]      <= wdata[2:0];
      end
      if (flag_we) status_q[2:0] <= flag_in;
    end
  end

  a_r7_flag_wins: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> status_q[2:0] == $past(flag_in));

  a_r6_write_fields: assert property (@(posedge clk) disable iff (rst)
    (we && !flag_we) |=> (status_q[2:0] == $past(wdata[2:0])) &&
                         (status_q[P_DW-1:5] == $past(wdata[P_DW-1:5])));

  a_r6_guard_bits: assert property (@(posedge clk) disable iff (rst)
    we |=> status_q[4:3] == $past(status_q[4:3]));
endmodule

// File: rtl/banked_dmem_ram.sv
module banked_dmem_ram #(
  parameter int P_AW = 9,
  parameter int P_DW = 8,
  localparam int DEPTH = 1 << P_AW
) (
  input  logic            clk,
  input  logic            re,
  input  logic            we,
  input  logic [P_AW-1:0] a,
  input  logic [P_DW-1:0] wd,
  output logic [P_DW-1:0] rq
);
  logic [P_DW-1:0] mem [DEPTH];

  // read-first single port: nonblocking read sees the pre-write byte
  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
    if (re) rq <= mem[a];
  end
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
  import banked_dmem_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [OFS_W-1:0]    addr,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  input  logic                flag_we,
  input  logic [2:0]          flag_in,
  output logic [DW-1:0]       status,
  output logic [DW-1:0]       pointer,
  output logic                ext_rd,
  output logic                ext_wr,
  output logic [EA_W-1:0]     ext_addr,
  input  logic [DW-1:0]       ext_rd_data
);
  localparam int IRP_BIT = DW - 1;
  localparam int RP_HI   = DW - 2;
  localparam int RP_LO   = RP_HI - BANK_W + 1;

  logic [EA_W-1:0] ea;
  dmem_rgn_e       rgn;
  logic [DW-1:0]   status_q;
  logic [DW-1:0]   ptr_q;
  logic [DW-1:0]   ram_q;
  logic [DW-1:0]   misc_q;
  logic            from_ram_q;
  logic            ram_we, ram_re, stat_we, ptr_we;

  banked_dmem_decode u_dec (
    .addr     (addr),
    .bank_dir (status_q[RP_HI:RP_LO]),
    .bank_ind (status_q[IRP_BIT]),
    .ptr      (ptr_q),
    .ea       (ea),
    .rgn      (rgn),
    .ext_ea   (ext_addr)
  );

  assign ram_we  = wr_en && (rgn == RG_RAM);
  assign ram_re  = rd_en && (rgn == RG_RAM);
  assign stat_we = wr_en && (rgn == RG_STAT);
  assign ptr_we  = wr_en && (rgn == RG_PTR);
  assign ext_wr  = wr_en && (rgn == RG_EXT);
  assign ext_rd  = rd_en && (rgn == RG_EXT);

  banked_dmem_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .we       (stat_we),
    .wdata    (wr_data),
    .flag_we  (flag_we),
    .flag_in  (flag_in),
    .status_q (status_q)
  );

  banked_dmem_ram #(.P_AW(EA_W), .P_DW(DW)) u_ram (
    .clk (clk),
    .re  (ram_re),
    .we  (ram_we),
    .a   (ea),
    .wd  (wr_data),
    .rq  (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (ptr_we) ptr_q <= wr_data;
  end

  // register-side read path, captured alongside the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      from_ram_q <= 1'b0;
      misc_q     <= '0;
    end else if (rd_en) begin
      from_ram_q <= (rgn == RG_RAM);
      unique case (rgn)
        RG_STAT: misc_q <= status_q;
        RG_PTR:  misc_q <= ptr_q;
        RG_EXT:  misc_q <= ext_rd_data;
        default: misc_q <= '0;
      endcase
    end
  end

  assign rd_data = from_ram_q ? ram_q : misc_q;
  assign status  = status_q;
  assign pointer = ptr_q;

  a_r11_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, stat_we, ptr_we, ext_wr}));

  a_r8_ext_capture: assert property (@(posedge clk) disable iff (rst)
    ext_rd |=> rd_data == $past(ext_rd_data));

  a_r4_null_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rgn == RG_NULL) |=> rd_data == '0);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r5_pointer_load: assert property (@(posedge clk) disable iff (rst)
    ptr_we |=> pointer == $past(wr_data));

  a_r4_null_no_store: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rgn == RG_NULL && !flag_we) |=> $stable(status) && $stable(pointer));
endmodule

// File: tb/tb_banked_dmem.sv
module tb_banked_dmem;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] addr;
  logic       rd_en, wr_en, flag_we;
  logic [7:0] wr_data, rd_data, status, pointer, ext_rd_data;
  logic [2:0] flag_in;
  logic       ext_rd, ext_wr;
  logic [8:0] ext_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign ext_rd_data = ext_addr[7:0] ^ 8'h5A;

  banked_dmem dut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .flag_we(flag_we), .flag_in(flag_in),
    .status(status), .pointer(pointer), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_addr(ext_addr), .ext_rd_data(ext_rd_data)
  );

  logic [7:0] mem_m [512];
  bit         vld_m [512];
  logic [7:0] st_m, ptr_m, rd_m;
  bit         rd_known;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // 0 null, 1 ram, 2 status, 3 pointer, 4 external
  function automatic int rgn_of(input logic [8:0] ea);
    logic [6:0] o = ea[6:0];
    if (o == 7'h00) return 0;
    if (o == 7'h03) return 2;
    if (o == 7'h04) return 3;
    if (o == 7'h02) return 4;
    if (ea[8:7] == 2'b00 && (o == 7'h01 || (o >= 7'h05 && o < 7'h20))) return 4;
    return 1;
  endfunction

  task automatic op(input logic [6:0] a, input bit re, input bit we,
                    input logic [7:0] wd, input bit fwe, input logic [2:0] fl);
    logic [8:0] ea, xa;
    int rg;
    logic [7:0] exp;
    bit known;
    string tag;
    ea = (a == 7'h00) ? {st_m[7], ptr_m} : {st_m[6:5], a};
    rg = rgn_of(ea);
    xa = (ea[6:0] == 7'h02) ? 9'h002 : ea;
    addr = a; rd_en = re; wr_en = we; wr_data = wd; flag_we = fwe; flag_in = fl;
    #1;
    chk("R8 ext_rd", {15'd0, ext_rd}, {15'd0, re && rg == 4});
    chk("R11 ext_wr", {15'd0, ext_wr}, {15'd0, we && rg == 4});
    if (rg == 4 && (re || we)) chk("R8 ext_addr", {7'd0, ext_addr}, {7'd0, xa});
    known = 1'b1;
    case (rg)
      0: begin exp = 8'h00; tag = "R4"; end
      2: begin exp = st_m; tag = "R5"; end
      3: begin exp = ptr_m; tag = "R5"; end
      4: begin exp = xa[7:0] ^ 8'h5A; tag = "R8"; end
      default: begin
        exp = mem_m[ea]; known = vld_m[ea];
        if (we) tag = "R10";
        else if (a == 7'h00) tag = "R3";
        else if (ea[8:7] != 2'b00 && ea[6:0] < 7'h20) tag = "R9";
        else tag = "R2";
      end
    endcase
    if (!re) tag = "R10";
    @(posedge clk); #1;
    if (we) begin
      case (rg)
        1: begin mem_m[ea] = wd; vld_m[ea] = 1'b1; end
        2: st_m = {wd[7:5], st_m[4:3], wd[2:0]};
        3: ptr_m = wd;
        default: ;
      endcase
    end
    if (fwe) st_m[2:0] = fl;
    if (re) begin rd_m = exp; rd_known = known; end
    if (rd_known) chk(tag, {8'd0, rd_data}, {8'd0, rd_m});
    chk(fwe ? "R7" : "R6", {8'd0, status}, {8'd0, st_m});
    chk("R5", {8'd0, pointer}, {8'd0, ptr_m});
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) vld_m[i] = 1'b0;
    st_m = 8'h18; ptr_m = 8'h00; rd_m = 8'h00; rd_known = 1'b1;
    rst = 1'b1; addr = '0; rd_en = 0; wr_en = 0; wr_data = '0; flag_we = 0; flag_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 status", {8'd0, status}, 16'h0018);
    chk("R1 pointer", {8'd0, pointer}, 16'h0000);
    chk("R1 rd_data", {8'd0, rd_data}, 16'h0000);
    @(negedge clk);

    // R6: guard bits survive a status write
    op(7'h03, 1, 1, 8'h27, 0, 3'b000);
    op(7'h03, 1, 0, 8'h00, 0, 3'b000);
    // R2 / R9: same offset in banks 1 and 0
    op(7'h30, 0, 1, 8'h11, 0, 3'b000);
    op(7'h01, 0, 1, 8'h33, 0, 3'b000);
    op(7'h03, 0, 1, 8'h00, 0, 3'b000);
    op(7'h30, 0, 1, 8'h22, 0, 3'b000);
    op(7'h30, 1, 0, 8'h00, 0, 3'b000);
    op(7'h01, 1, 0, 8'h00, 0, 3'b000);
    op(7'h03, 0, 1, 8'h20, 0, 3'b000);
    op(7'h30, 1, 0, 8'h00, 0, 3'b000);
    op(7'h01, 1, 0, 8'h00, 0, 3'b000);
    op(7'h00, 0, 0, 8'h00, 0, 3'b000);
    // R3: pointer access into bank 1 and upper half
    op(7'h04, 0, 1, 8'hB0, 0, 3'b000);
    op(7'h00, 1, 0, 8'h00, 0, 3'b000);
    op(7'h03, 0, 1, 8'h80, 0, 3'b000);
    op(7'h00, 1, 1, 8'h77, 0, 3'b000);
    op(7'h00, 1, 0, 8'h00, 0, 3'b000);
    // R4: null location with pointer 0x00 and 0x80
    op(7'h04, 0, 1, 8'h00, 0, 3'b000);
    op(7'h00, 1, 1, 8'hFF, 0, 3'b000);
    op(7'h04, 0, 1, 8'h80, 0, 3'b000);
    op(7'h00, 1, 1, 8'hFF, 0, 3'b000);
    // R5: pointer reaching status and itself
    op(7'h04, 0, 1, 8'h03, 0, 3'b000);
    op(7'h00, 1, 0, 8'h00, 0, 3'b000);
    op(7'h00, 0, 1, 8'h05, 0, 3'b000);
    op(7'h04, 0, 1, 8'h84, 0, 3'b000);
    op(7'h00, 1, 1, 8'h9C, 0, 3'b000);
    // R7: flag update beats a status write, and alone
    op(7'h03, 0, 1, 8'h07, 1, 3'b010);
    op(7'h40, 0, 0, 8'h00, 1, 3'b101);
    // R8: external window, PC low mirror in bank 3
    op(7'h03, 0, 1, 8'h60, 0, 3'b000);
    op(7'h02, 1, 1, 8'h12, 0, 3'b000);
    op(7'h03, 0, 1, 8'h00, 0, 3'b000);
    op(7'h01, 1, 0, 8'h00, 0, 3'b000);
    op(7'h1F, 1, 1, 8'h44, 0, 3'b000);
    op(7'h05, 1, 0, 8'h00, 0, 3'b000);
    // R10: read during write, then hold
    op(7'h50, 0, 1, 8'hA1, 0, 3'b000);
    op(7'h50, 1, 1, 8'hB2, 0, 3'b000);
    op(7'h50, 0, 0, 8'h00, 0, 3'b000);
    op(7'h50, 1, 0, 8'h00, 0, 3'b000);

    for (int i = 0; i < 3000; i++) begin
      logic [6:0] a;
      int pick = int'($urandom % 8);
      case (pick)
        0: a = 7'h00;
        1: a = 7'h03;
        2: a = 7'h04;
        3: a = 7'h02;
        default: a = 7'($urandom);
      endcase
      op(a, 1'($urandom % 2), ($urandom % 3) == 0, 8'($urandom),
         ($urandom % 4) == 0, 3'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule